// File: doc/BRIEF.md
# Parallel Camera Frame Capture

This block takes pixels from a parallel camera port and turns them into 32-bit words for a DMA-style reader. The camera side is a pixel clock, a data bus that carries 8, 10, 12 or 14 significant bits, and either two separate sync lines or sync codes embedded in the data. Both the pixel clock and the camera signals are treated as slow inputs that are synchronous to the system clock. The block finds the chosen pixel-clock edge by comparing each input value with the value it saw one system clock earlier.

Software programs a control register, an interrupt-enable register and a write-one-to-clear status register through a plain register port. Capture runs only while both the enable bit and the capture bit are set. In snapshot mode exactly one frame is taken, and then the block clears the capture bit itself. In continuous mode a frame-rate field can keep every frame, every second frame or every fourth frame. Samples within a frame are packed into words and written into a small word FIFO. A partial word left at the end of a frame is written out with zero padding. Frame done, overrun and sync error each raise a status flag. The interrupt is the OR of the flags whose enable bit is set.

Top module: `cam_capture`

## Requirements
- R1: After reset the control register reads 0x030 (pixel clock on the rising edge = bit 4, VSYNC high means blanking = bit 5, all other bits 0). Status reads 0, the FIFO is empty and irq is low. Register addresses: 0 control, 1 interrupt enable, 2 status (read), 3 clear (write ones). Status and enable bits: 0 frame done, 1 overrun, 2 sync error.
- R2: With width code 00 (control bits 10:9), four 8-bit samples are packed into each word. The first sample goes in bits 7:0 and the fourth in bits 31:24.
- R3: With width codes 01, 10 and 11 (10, 12 and 14 bits), two samples are packed into each word. Each sample is masked to the selected width and right-aligned in its 16-bit half, with the first sample in bits 15:0.
- R4: A frame is captured only when enable (bit 0) and capture (bit 1) are both set at the frame start. With either bit clear, no word is written and no frame flag is set.
- R5: Control bit 4 selects the sampling edge: 1 samples on the rising pixel-clock edge and 0 on the falling edge.
- R6: Control bit 5 = 1 makes VSYNC high mark blanking, and 0 makes VSYNC low mark blanking. Bit 6 does the same for HSYNC. Samples are taken only while neither line is at its blanking level. A frame starts when VSYNC leaves blanking and ends when it returns to blanking.
- R7: With snapshot (bit 2) set, the block clears the capture bit when the frame completes, and later frames write nothing.
- R8: In continuous mode the frame-rate field (bits 8:7) keeps every frame for 00, every second frame for 01, and every fourth frame for 10 or 11. The first frame after capture is armed is always kept.
- R9: At the end of a captured frame, a partial word is written with its unused samples set to zero, and the frame-done flag is set.
- R10: A word that must be written while the FIFO is full and is not being read is dropped, and the overrun flag is set. The words already in the FIFO are kept.
- R11: In embedded mode (bit 3) the sync pins are ignored. A code is the byte sequence FF,00,00 followed by a code byte, all read from data bits 7:0. In the code byte, bit 0 = frame start, bit 1 = frame end, bit 2 = line start and bit 3 = line end. Samples between a line start and a line end inside a frame are captured, and the four code bytes are never captured.
- R12: In embedded mode, a code byte after FF,00,00 whose upper nibble is nonzero, or whose lower nibble does not have exactly one bit set, sets the sync-error flag.
- R13: irq is high exactly when some status flag and its enable bit are both set. Writing a one to the clear register clears that status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cam_pclk | input | 1 | Camera pixel clock, sampled by clk |
| cam_vsync | input | 1 | Frame sync line (ignored in embedded mode) |
| cam_hsync | input | 1 | Line sync line (ignored in embedded mode) |
| cam_data | input | 14 | Camera data bus, low bits significant for narrow widths |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 11 | Register write data |
| reg_rdata | output | 11 | Register read data (combinational) |
| fifo_valid | output | 1 | Word FIFO holds at least one word |
| fifo_data | output | 32 | Oldest word in the FIFO |
| fifo_pop | input | 1 | Reader takes the oldest word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the embedded-sync line end. There the three bytes before the code have already entered the capture path as pixels and must be withdrawn, while the real pixels just before them must still come out. The bench sends a line whose pixel count is not a multiple of four. The words it expects then show that every pixel reached the FIFO, that no preamble byte did, and that the frame-end flush padded the final sample. A second hard case is frame decimation: the bench sends four back-to-back continuous frames with distinct data and checks that only the first and third frames appear.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
    localparam int SAMPLE_W = 14;
    localparam int WORD_W   = 32;
    localparam int NFLAGS   = 3;

    typedef struct packed {
        logic [1:0] width;
        logic [1:0] skip;
        logic       hs_blank_hi;
        logic       vs_blank_hi;
        logic       pclk_rise;
        logic       embedded;
        logic       snapshot;
        logic       capture;
        logic       enable;
    } ctrl_t;

    localparam int REG_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RESET = '{width: 2'b00, skip: 2'b00, hs_blank_hi: 1'b0,
                                     vs_blank_hi: 1'b1, pclk_rise: 1'b1, embedded: 1'b0,
                                     snapshot: 1'b0, capture: 1'b0, enable: 1'b0};

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_IE   = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_CLR  = 2'd3;

    localparam int ST_FRAME = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_SERR  = 2;
endpackage

// File: rtl/cam_frontend.sv
module cam_frontend
    import cam_cap_pkg::*;
#(
    parameter int DLY = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                embedded,
    input  logic                pclk_rise,
    input  logic                vs_blank_hi,
    input  logic                hs_blank_hi,
    input  logic                cam_pclk,
    input  logic                cam_vsync,
    input  logic                cam_hsync,
    input  logic [SAMPLE_W-1:0] cam_data,
    output logic                smp_vld,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic                frm_start,
    output logic                frm_end,
    output logic                sync_err
);
    typedef struct packed {
        logic                          pclk;
        logic                          vs_act;
        logic                          in_frame;
        logic                          in_line;
        logic [DLY-1:0][7:0]           hist;
        logic [DLY-1:0][SAMPLE_W-1:0]  dly;
        logic [DLY-1:0]                dly_v;
    } fe_t;

    fe_t q, d;
    logic ev, vs_act, hs_act, preamble, code_ok;
    logic [7:0] code;

    always_comb begin
        d         = q;
        smp_vld   = 1'b0;
        smp_data  = cam_data;
        frm_start = 1'b0;
        frm_end   = 1'b0;
        sync_err  = 1'b0;
        d.pclk    = cam_pclk;
        ev        = (cam_pclk != q.pclk) && (cam_pclk == pclk_rise);
        vs_act    = (cam_vsync != vs_blank_hi);
        hs_act    = (cam_hsync != hs_blank_hi);
        code      = cam_data[7:0];
        preamble  = (q.hist[2] == 8'hFF) && (q.hist[1] == 8'h00) && (q.hist[0] == 8'h00);
        code_ok   = (code[7:4] == 4'h0) && $onehot(code[3:0]);
        if (ev) begin
            if (!embedded) begin
                frm_start = vs_act && !q.vs_act;
                frm_end   = !vs_act && q.vs_act;
                smp_vld   = vs_act && hs_act;
                d.vs_act  = vs_act;
            end else begin
                d.hist = {q.hist[DLY-2:0], code};
                if (preamble) begin
                    // code byte: withdraw the preamble bytes still in the delay line
                    d.dly_v = '0;
                    if (!code_ok) begin
                        sync_err = 1'b1;
                    end else begin
                        if (code[0]) begin
                            d.in_frame = 1'b1;
                            frm_start  = 1'b1;
                        end
                        if (code[1]) begin
                            d.in_frame = 1'b0;
                            d.in_line  = 1'b0;
                            frm_end    = q.in_frame;
                        end
                        if (code[2]) d.in_line = q.in_frame;
                        if (code[3]) d.in_line = 1'b0;
                    end
                end else begin
                    smp_vld  = q.dly_v[DLY-1];
                    smp_data = q.dly[DLY-1];
                    d.dly    = {q.dly[DLY-2:0], cam_data};
                    d.dly_v  = {q.dly_v[DLY-2:0], q.in_frame && q.in_line};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cam_packer.sv
module cam_packer
    import cam_cap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          width,
    input  logic                in_vld,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                flush,
    output logic                push,
    output logic [WORD_W-1:0]   word
);
    localparam int LANES8  = WORD_W / 8;
    localparam int LANES16 = WORD_W / 16;
    localparam int CNT_W   = $clog2(LANES8);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
    } pk_t;

    pk_t q, d;
    logic                narrow, last;
    logic [SAMPLE_W-1:0] mask;
    logic [WORD_W-1:0]   lane, merged;

    always_comb begin
        d      = q;
        push   = 1'b0;
        word   = q.acc;
        narrow = (width == 2'b00);
        case (width)
            2'b01:   mask = SAMPLE_W'(14'h03FF);
            2'b10:   mask = SAMPLE_W'(14'h0FFF);
            default: mask = '1;
        endcase
        if (narrow) lane = WORD_W'(in_data[7:0]) << (8 * q.cnt);
        else        lane = WORD_W'(in_data & mask) << (16 * q.cnt);
        merged = q.acc | lane;
        last   = narrow ? (q.cnt == CNT_W'(LANES8 - 1)) : (q.cnt == CNT_W'(LANES16 - 1));
        if (flush) begin
            push  = (q.cnt != '0);
            d.acc = '0;
            d.cnt = '0;
        end else if (in_vld) begin
            if (last) begin
                push  = 1'b1;
                word  = merged;
                d.acc = '0;
                d.cnt = '0;
            end else begin
                d.acc = merged;
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cam_word_fifo.sv
module cam_word_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic         full,
    output logic         valid,
    output logic [W-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } ff_t;

    ff_t q, d;
    logic do_pop, do_push;

    always_comb begin
        d       = q;
        full    = (q.cnt == CW'(DEPTH));
        valid   = (q.cnt != '0);
        rdata   = q.mem[q.rd];
        do_pop  = pop && valid;
        do_push = push && (!full || do_pop);
        if (do_push) begin
            d.mem[q.wr] = wdata;
            d.wr = (q.wr == AW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        if (do_pop) d.rd = (q.rd == AW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
        else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cam_capture.sv
module cam_capture
    import cam_cap_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cam_pclk,
    input  logic                cam_vsync,
    input  logic                cam_hsync,
    input  logic [SAMPLE_W-1:0] cam_data,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                fifo_valid,
    output logic [WORD_W-1:0]   fifo_data,
    input  logic                fifo_pop,
    output logic                irq
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [NFLAGS-1:0] ie;
        logic [NFLAGS-1:0] stat;
        logic              capturing;
        logic [1:0]        skip_cnt;
    } top_t;

    top_t q, d;
    ctrl_t             ctrl_q;
    logic [NFLAGS-1:0] stat_q;
    logic              capturing_q;

    logic smp_vld, frm_start, frm_end, sync_err;
    logic [SAMPLE_W-1:0] smp_data;
    logic push_w, fifo_full_w, frame_done, ovr_evt, go;
    logic [WORD_W-1:0] word_w;
    logic [1:0] skip_mask;

    assign ctrl_q      = q.ctrl;
    assign stat_q      = q.stat;
    assign capturing_q = q.capturing;

    cam_frontend u_front (
        .clk(clk), .rst_n(rst_n),
        .embedded(ctrl_q.embedded), .pclk_rise(ctrl_q.pclk_rise),
        .vs_blank_hi(ctrl_q.vs_blank_hi), .hs_blank_hi(ctrl_q.hs_blank_hi),
        .cam_pclk(cam_pclk), .cam_vsync(cam_vsync), .cam_hsync(cam_hsync),
        .cam_data(cam_data), .smp_vld(smp_vld), .smp_data(smp_data),
        .frm_start(frm_start), .frm_end(frm_end), .sync_err(sync_err)
    );

    cam_packer u_pack (
        .clk(clk), .rst_n(rst_n), .width(ctrl_q.width),
        .in_vld(smp_vld && capturing_q), .in_data(smp_data),
        .flush(frame_done), .push(push_w), .word(word_w)
    );

    cam_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_w), .wdata(word_w),
        .pop(fifo_pop), .full(fifo_full_w), .valid(fifo_valid), .rdata(fifo_data)
    );

    always_comb begin
        d          = q;
        go         = ctrl_q.enable && ctrl_q.capture;
        frame_done = frm_end && capturing_q;
        ovr_evt    = push_w && fifo_full_w && !fifo_pop;
        case (ctrl_q.skip)
            2'b00:   skip_mask = 2'b00;
            2'b01:   skip_mask = 2'b01;
            default: skip_mask = 2'b11;
        endcase
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL:  d.ctrl = ctrl_t'(reg_wdata);
                A_IE:    d.ie   = reg_wdata[NFLAGS-1:0];
                A_CLR:   d.stat = q.stat & ~reg_wdata[NFLAGS-1:0];
                default: ;
            endcase
        end
        if (!go) d.skip_cnt = '0;
        if (frm_start && go) begin
            d.skip_cnt = q.skip_cnt + 1'b1;
            if ((q.skip_cnt & skip_mask) == 2'b00) d.capturing = 1'b1;
        end
        if (frame_done) begin
            d.capturing = 1'b0;
            if (ctrl_q.snapshot) d.ctrl.capture = 1'b0;
        end
        if (!ctrl_q.enable) d.capturing = 1'b0;
        d.stat[ST_FRAME] = d.stat[ST_FRAME] | frame_done;
        d.stat[ST_OVR]   = d.stat[ST_OVR]   | ovr_evt;
        d.stat[ST_SERR]  = d.stat[ST_SERR]  | (sync_err && ctrl_q.enable);
        case (reg_addr)
            A_CTRL:  reg_rdata = REG_W'(ctrl_q);
            A_IE:    reg_rdata = REG_W'(q.ie);
            A_STAT:  reg_rdata = REG_W'(stat_q);
            default: reg_rdata = '0;
        endcase
        irq = |(stat_q & q.ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ctrl <= CTRL_RESET;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk
    import cam_cap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input ctrl_t             ctrl_q,
    input logic [NFLAGS-1:0] stat_q,
    input logic              capturing_q,
    input logic              push_w,
    input logic              fifo_full_w,
    input logic              fifo_pop,
    input logic              frame_done,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [NFLAGS-1:0] clr_bits
);
    p_overrun_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_w && fifo_full_w && !fifo_pop |=> stat_q[ST_OVR]);

    p_frame_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> stat_q[ST_FRAME]);

    p_push_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_w |-> capturing_q);

    p_snapshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && ctrl_q.snapshot && !(reg_wr && reg_addr == A_CTRL) |=> !ctrl_q.capture);

    p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !capturing_q && !(ctrl_q.enable && ctrl_q.capture) |=> !capturing_q);

    p_w1c_r13: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_CLR && clr_bits[ST_FRAME] && !frame_done |=> !stat_q[ST_FRAME]);
endmodule

bind cam_capture cam_capture_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .capturing_q(capturing_q), .push_w(push_w), .fifo_full_w(fifo_full_w),
    .fifo_pop(fifo_pop), .frame_done(frame_done), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .clr_bits(reg_wdata[2:0])
);

// File: tb/cam_capture_tb_top.sv
`timescale 1ns/1ps
module cam_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cam_pclk = 1'b0, cam_vsync = 1'b1, cam_hsync = 1'b0;
    logic [13:0] cam_data = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [10:0] reg_wdata = '0;
    logic [10:0] reg_rdata;
    logic        fifo_valid, fifo_pop = 1'b0, irq;
    logic [31:0] fifo_data;

    int nchk = 0, nfail = 0;
    bit rise_mode = 1'b1, vs_blank = 1'b1, hs_blank = 1'b0;
    logic [31:0] expq[$];
    logic [31:0] macc = '0;
    int mcnt = 0;

    always #2.5 clk = ~clk;

    cam_capture dut_i (
        .clk(clk), .rst_n(rst_n), .cam_pclk(cam_pclk), .cam_vsync(cam_vsync),
        .cam_hsync(cam_hsync), .cam_data(cam_data), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop), .irq(irq)
    );

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] cfgv(bit en, bit cap, bit snap, bit emb, bit rise,
                                         bit vsh, bit hsh, logic [1:0] skip, logic [1:0] w);
        return {w, skip, hsh, vsh, rise, emb, snap, cap, en};
    endfunction

    task automatic wr(logic [1:0] a, logic [10:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [10:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic px(logic [13:0] dv, bit vs, bit hs);
        cam_vsync = vs; cam_hsync = hs;
        cam_data = rise_mode ? dv : ~dv;
        step(2);
        cam_pclk = 1'b1;
        step(1);
        cam_data = rise_mode ? ~dv : dv;
        step(2);
        cam_pclk = 1'b0;
        step(1);
    endtask

    task automatic m_add(logic [13:0] s, logic [1:0] w);
        logic [13:0] mk;
        if (w == 2'b00) begin
            macc |= 32'(s[7:0]) << (8 * mcnt);
            mcnt++;
            if (mcnt == 4) begin expq.push_back(macc); macc = '0; mcnt = 0; end
        end else begin
            mk = (w == 2'b01) ? 14'h03FF : (w == 2'b10) ? 14'h0FFF : 14'h3FFF;
            macc |= 32'(s & mk) << (16 * mcnt);
            mcnt++;
            if (mcnt == 2) begin expq.push_back(macc); macc = '0; mcnt = 0; end
        end
    endtask

    task automatic m_flush();
        if (mcnt != 0) expq.push_back(macc);
        macc = '0; mcnt = 0;
    endtask

    task automatic frame_ext(int lines, int ppl, int base, bit keep, logic [1:0] w);
        logic [13:0] dv;
        px(14'h2A5, vs_blank, hs_blank);
        px(14'h2A5, vs_blank, hs_blank);
        for (int l = 0; l < lines; l++) begin
            px(14'h155, !vs_blank, hs_blank);
            for (int k = 0; k < ppl; k++) begin
                dv = 14'(base + l * ppl + k);
                px(dv, !vs_blank, !hs_blank);
                if (keep) m_add(dv, w);
            end
            px(14'h155, !vs_blank, hs_blank);
        end
        px(14'h2A5, vs_blank, hs_blank);
        px(14'h2A5, vs_blank, hs_blank);
        if (keep) m_flush();
    endtask

    task automatic drain(string req);
        int idx = 0;
        while (expq.size() > 0) begin
            chk(req, $sformatf("word %0d valid", idx), 32'(fifo_valid), 32'd1);
            chk(req, $sformatf("word %0d data", idx), fifo_data, expq.pop_front());
            fifo_pop = 1'b1;
            step(1);
            fifo_pop = 1'b0;
            idx++;
        end
        chk(req, "fifo empty after drain", 32'(fifo_valid), 32'd0);
    endtask

    task automatic t_reset();
        logic [10:0] v;
        rd(2'd0, v); chk("R1", "ctrl reset", 32'(v), 32'h030);
        rd(2'd2, v); chk("R1", "status reset", 32'(v), 32'h0);
        chk("R1", "irq reset", 32'(irq), 32'd0);
        chk("R1", "fifo empty", 32'(fifo_valid), 32'd0);
    endtask

    task automatic t_gate();
        logic [10:0] v;
        wr(2'd0, cfgv(1, 0, 1, 0, 1, 1, 0, 2'b00, 2'b00));
        frame_ext(1, 4, 8'h20, 0, 2'b00);
        chk("R4", "no word enable only", 32'(fifo_valid), 32'd0);
        rd(2'd2, v); chk("R4", "no flag enable only", 32'(v), 32'h0);
        wr(2'd0, cfgv(0, 1, 1, 0, 1, 1, 0, 2'b00, 2'b00));
        frame_ext(1, 4, 8'h30, 0, 2'b00);
        chk("R4", "no word capture only", 32'(fifo_valid), 32'd0);
        rd(2'd2, v); chk("R4", "no flag capture only", 32'(v), 32'h0);
    endtask

    task automatic t_pack8();
        logic [10:0] v;
        wr(2'd1, 11'h1);
        wr(2'd0, cfgv(1, 1, 1, 0, 1, 1, 0, 2'b00, 2'b00));
        frame_ext(2, 3, 8'h11, 1, 2'b00);
        rd(2'd2, v); chk("R9", "frame flag", 32'(v), 32'h1);
        chk("R13", "irq on enabled frame flag", 32'(irq), 32'd1);
        rd(2'd0, v); chk("R7", "capture bit cleared", 32'(v),
                          32'(cfgv(1, 0, 1, 0, 1, 1, 0, 2'b00, 2'b00)));
        drain("R2 R9");
        wr(2'd3, 11'h1);
        rd(2'd2, v); chk("R13", "status after clear", 32'(v), 32'h0);
        chk("R13", "irq after clear", 32'(irq), 32'd0);
        frame_ext(1, 4, 8'h50, 0, 2'b00);
        chk("R7", "no capture after snapshot", 32'(fifo_valid), 32'd0);
        rd(2'd2, v); chk("R7", "no flag after snapshot", 32'(v), 32'h0);
    endtask

    task automatic t_wide();
        wr(2'd0, cfgv(1, 1, 1, 0, 1, 1, 0, 2'b00, 2'b01));
        frame_ext(1, 3, 14'h3C01, 1, 2'b01);
        drain("R3 10-bit");
        wr(2'd0, cfgv(1, 1, 1, 0, 1, 1, 0, 2'b00, 2'b10));
        frame_ext(1, 2, 14'h2F05, 1, 2'b10);
        drain("R3 12-bit");
        wr(2'd0, cfgv(1, 1, 1, 0, 1, 1, 0, 2'b00, 2'b11));
        frame_ext(1, 2, 14'h3FF0, 1, 2'b11);
        drain("R3 14-bit");
        wr(2'd3, 11'h7);
    endtask

    task automatic t_polarity();
        rise_mode = 1'b0; vs_blank = 1'b0; hs_blank = 1'b1;
        cam_vsync = 1'b0; cam_hsync = 1'b1;
        wr(2'd0, cfgv(1, 1, 1, 0, 0, 0, 1, 2'b00, 2'b00));
        frame_ext(1, 4, 8'h61, 1, 2'b00);
        drain("R5 R6");
        rise_mode = 1'b1; vs_blank = 1'b1; hs_blank = 1'b0;
        wr(2'd0, cfgv(1, 0, 1, 0, 1, 1, 0, 2'b00, 2'b00));
        px(14'h0, 1'b1, 1'b0);
        wr(2'd3, 11'h7);
    endtask

    task automatic t_skip();
        wr(2'd0, cfgv(1, 1, 0, 0, 1, 1, 0, 2'b01, 2'b00));
        frame_ext(1, 4, 8'h10, 1, 2'b00);
        frame_ext(1, 4, 8'h20, 0, 2'b00);
        frame_ext(1, 4, 8'h30, 1, 2'b00);
        frame_ext(1, 4, 8'h40, 0, 2'b00);
        wr(2'd0, 11'h030);
        drain("R8");
        wr(2'd3, 11'h7);
    endtask

    task automatic t_ovr();
        logic [10:0] v;
        wr(2'd1, 11'h2);
        wr(2'd0, cfgv(1, 1, 1, 0, 1, 1, 0, 2'b00, 2'b00));
        frame_ext(1, 24, 8'h40, 1, 2'b00);
        while (expq.size() > 4) void'(expq.pop_back());
        rd(2'd2, v); chk("R10", "overrun and frame flags", 32'(v), 32'h3);
        chk("R10", "irq on overrun", 32'(irq), 32'd1);
        drain("R10");
        wr(2'd3, 11'h7);
        chk("R13", "irq after clearing overrun", 32'(irq), 32'd0);
    endtask

    task automatic emb_code(logic [7:0] c, int seed);
        px(14'h0FF, seed[0], seed[1]);
        px(14'h000, seed[1], seed[0]);
        px(14'h000, seed[0], 1'b1);
        px(14'(c), 1'b0, seed[1]);
    endtask

    task automatic t_emb();
        logic [10:0] v;
        logic [7:0] pix [5] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A};
        wr(2'd1, 11'h1);
        wr(2'd0, cfgv(1, 1, 1, 1, 1, 1, 0, 2'b00, 2'b00));
        emb_code(8'h01, 1);
        emb_code(8'h04, 2);
        for (int i = 0; i < 5; i++) px(14'(pix[i]), i[0], i[1]);
        emb_code(8'h08, 3);
        emb_code(8'h02, 0);
        expq.push_back(32'h78563412);
        expq.push_back(32'h0000009A);
        rd(2'd2, v); chk("R11", "frame flag embedded", 32'(v), 32'h1);
        drain("R11");
        wr(2'd3, 11'h7);
    endtask

    task automatic t_err();
        logic [10:0] v;
        wr(2'd1, 11'h4);
        emb_code(8'h35, 1);
        rd(2'd2, v); chk("R12", "sync error flag", 32'(v), 32'h4);
        chk("R12", "irq on sync error", 32'(irq), 32'd1);
        chk("R12", "no word on bad code", 32'(fifo_valid), 32'd0);
    endtask

    task automatic run_all();
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_gate();
        t_pack8();
        t_wide();
        t_polarity();
        t_skip();
        t_ovr();
        t_emb();
        t_err();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                nchk++; nfail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule